// File: doc/BRIEF.md
# Interrupt pending register and request qualifier

The block holds the pending state of a small number of interrupt levels for a processor core and decides when the core is interrupted. Peripherals set or clear one level at a time by strobing an index. A single strobe empties the whole vector. A built-in timer comparison also raises a level: the software can choose which one. The block compares a free-running count with a compare value, and when the two match it sets that chosen level. A match while the count is zero is not treated as a timer event.

The pending vector is ANDed with a per-level mask. A request goes to the pipeline only if some masked level is pending, the global interrupt enable is set, and neither the error-level flag nor the exception-level flag is set. An index that names no existing level leaves the vector unchanged and is reported by a one-cycle error pulse.

Top module: `irq_pending_unit`

## Requirements
- R1: A synchronous active-high reset sets `pending`, `irq_req` and `index_err` to 0.
- R2: A `post_stb` with a `post_idx` value n in 0..NLEV-1 sets `pending[n]` at the next clock edge and leaves the other bits unchanged.
- R3: A `clr_stb` with a `clr_idx` value n in 0..NLEV-1 clears `pending[n]` at the next clock edge and leaves the other bits unchanged.
- R4: A `clr_all` strobe forces `pending` to all zeros at the next edge. This takes priority over any post, clear or timer event in the same cycle.
- R5: A post or clear strobe whose index is NLEV or above (8..15 with the default 4-bit index) does not change `pending`. `index_err` is 1 for exactly the cycle after such a strobe and 0 otherwise.
- R6: When `count_val` equals `compare_val` and `count_val` is nonzero, `pending[timer_sel]` is set at the next edge. Equal values with a zero count set nothing.
- R7: `irq_req` is 0 in the cycle after any cycle in which `glob_en` is 0, `err_lvl` is 1 or `exc_lvl` is 1.
- R8: `irq_req` is registered. It equals, one edge later, the OR of `irq_mask & pending` gated by the R7 conditions, using the register `pending` value. It is therefore 0 after any cycle in which `pending` is all zeros.
- R9: When a post and a clear name the same level in the same cycle, the post wins and the bit ends up set. A timer event also wins over a clear of its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_stb | input | 1 | Set one pending level |
| post_idx | input | IDXW | Level to set |
| clr_stb | input | 1 | Clear one pending level |
| clr_idx | input | IDXW | Level to clear |
| clr_all | input | 1 | Clear every pending level |
| glob_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error-level flag, blocks requests when 1 |
| exc_lvl | input | 1 | Exception-level flag, blocks requests when 1 |
| irq_mask | input | NLEV | Per-level enable mask |
| count_val | input | CNTW | Running count value |
| compare_val | input | CNTW | Timer compare value |
| timer_sel | input | $clog2(NLEV) | Level set by a timer match |
| pending | output | NLEV | Pending level vector |
| irq_req | output | 1 | Qualified interrupt request |
| index_err | output | 1 | One-cycle pulse after an out-of-range index |

## Verification
The bench builds the block with NLEV=8, IDXW=4 and CNTW=4. With these values every index value, legal and illegal, can be posted and cleared, and every post/clear pair is applied to a mixed pattern. All 256 count/compare pairs are swept with a rotating timer level, so both the zero-count exclusion and every timer level are covered. Each of the 256 masks is tried against several pending patterns under all eight combinations of the enable and the two state flags. The expected values come from a reference model of the requirements that runs beside the block, one clock at a time.

// File: rtl/irq_pending_unit.sv
module irq_pending_unit #(
  parameter int NLEV = 8,
  parameter int IDXW = 4,
  parameter int CNTW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    post_stb,
  input  logic [IDXW-1:0]         post_idx,
  input  logic                    clr_stb,
  input  logic [IDXW-1:0]         clr_idx,
  input  logic                    clr_all,
  input  logic                    glob_en,
  input  logic                    err_lvl,
  input  logic                    exc_lvl,
  input  logic [NLEV-1:0]         irq_mask,
  input  logic [CNTW-1:0]         count_val,
  input  logic [CNTW-1:0]         compare_val,
  input  logic [$clog2(NLEV)-1:0] timer_sel,
  output logic [NLEV-1:0]         pending,
  output logic                    irq_req,
  output logic                    index_err
);
  localparam int SELW = $clog2(NLEV);

  logic post_ok, clr_ok, post_bad, clr_bad, timer_hit, qual_ok;
  logic [NLEV-1:0] post_m, clr_m, tmr_m, pend_nx;

  assign post_ok   = post_stb && (32'(post_idx) < NLEV);
  assign clr_ok    = clr_stb  && (32'(clr_idx)  < NLEV);
  assign post_bad  = post_stb && !post_ok;
  assign clr_bad   = clr_stb  && !clr_ok;
  assign timer_hit = (count_val == compare_val) && (count_val != '0);
  assign qual_ok   = glob_en && !err_lvl && !exc_lvl;

  assign post_m  = post_ok   ? (NLEV'(1) << post_idx)  : '0;
  assign clr_m   = clr_ok    ? (NLEV'(1) << clr_idx)   : '0;
  assign tmr_m   = timer_hit ? (NLEV'(1) << timer_sel) : '0;
  assign pend_nx = clr_all ? '0 : ((pending & ~clr_m) | post_m | tmr_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      irq_req   <= 1'b0;
      index_err <= 1'b0;
    end else begin
      pending   <= pend_nx;
      irq_req   <= qual_ok && |(irq_mask & pending);
      index_err <= post_bad || clr_bad;
    end
  end

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (pending == '0));

  assert_post_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all) |=> pending[$past(post_idx[SELW-1:0])]);

  assert_bad_index_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (post_bad && !clr_stb && !clr_all && !timer_hit) |=> $stable(pending));

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
    index_err |-> $past(post_stb || clr_stb));

  assert_timer_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (timer_hit && !clr_all) |=> pending[$past(timer_sel)]);

  assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (!glob_en || err_lvl || exc_lvl) |=> !irq_req);

  assert_no_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |=> !irq_req);
endmodule

// File: tb/irq_pending_unit_tb.sv
module irq_pending_unit_tb_top;
  localparam int NLEV = 8, IDXW = 4, CNTW = 4;
  logic clk = 0, rst = 1;
  logic post_stb = 0, clr_stb = 0, clr_all = 0;
  logic [IDXW-1:0] post_idx = 0, clr_idx = 0;
  logic glob_en = 0, err_lvl = 0, exc_lvl = 0;
  logic [NLEV-1:0] irq_mask = 0;
  logic [CNTW-1:0] count_val = 0, compare_val = 0;
  logic [2:0] timer_sel = 0;
  logic [NLEV-1:0] pending;
  logic irq_req, index_err;
  int errors = 0, checks = 0;
  logic [NLEV-1:0] m_pend = 0;

  always #5 clk = ~clk;

  irq_pending_unit #(.NLEV(NLEV), .IDXW(IDXW), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst(rst), .post_stb(post_stb), .post_idx(post_idx),
    .clr_stb(clr_stb), .clr_idx(clr_idx), .clr_all(clr_all),
    .glob_en(glob_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl),
    .irq_mask(irq_mask), .count_val(count_val), .compare_val(compare_val),
    .timer_sel(timer_sel), .pending(pending), .irq_req(irq_req),
    .index_err(index_err));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic [NLEV-1:0] nx;
    logic exp_irq, exp_err;
    exp_irq = glob_en && !err_lvl && !exc_lvl && ((irq_mask & m_pend) != 0);
    exp_err = (post_stb && post_idx >= NLEV) || (clr_stb && clr_idx >= NLEV);
    nx = m_pend;
    if (clr_stb && clr_idx < NLEV) nx[clr_idx[2:0]] = 1'b0;
    if (count_val == compare_val && count_val != 0) nx[timer_sel] = 1'b1;
    if (post_stb && post_idx < NLEV) nx[post_idx[2:0]] = 1'b1;
    if (clr_all) nx = 0;
    m_pend = nx;
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(pending), int'(m_pend));
    chk("R7/R8 irq_req", int'(irq_req), int'(exp_irq));
    chk("R5 index_err", int'(index_err), int'(exp_err));
    post_stb = 0; clr_stb = 0; clr_all = 0;
  endtask

  task automatic wipe();
    clr_all = 1; count_val = 0; compare_val = 1;
    tick("R4 clear-all");
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    compare_val = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 pending", int'(pending), 0);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 index_err", int'(index_err), 0);

    for (int i = 0; i < 16; i++) begin
      post_stb = 1; post_idx = IDXW'(i);
      tick(i < NLEV ? "R2 post" : "R5 post out of range");
      wipe();
    end

    for (int i = 0; i < NLEV; i++) begin
      post_stb = 1; post_idx = IDXW'(i); tick("R2 fill");
    end
    for (int i = 15; i >= 0; i--) begin
      clr_stb = 1; clr_idx = IDXW'(i);
      tick(i < NLEV ? "R3 clear" : "R5 clear out of range");
    end

    for (int p = 0; p < NLEV; p++)
      for (int c = 0; c < NLEV; c++) begin
        wipe();
        for (int b = 0; b < NLEV; b++)
          if ((8'hA5 >> b) & 1) begin post_stb = 1; post_idx = IDXW'(b); tick("R2 preload"); end
        post_stb = 1; post_idx = IDXW'(p); clr_stb = 1; clr_idx = IDXW'(c);
        tick(p == c ? "R9 post beats clear" : "R2/R3 post and clear");
      end

    post_stb = 1; post_idx = 3; tick("R2 before clear-all");
    clr_all = 1; post_stb = 1; post_idx = 5; count_val = 2; compare_val = 2;
    timer_sel = 6; tick("R4 clear-all wins");

    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 16; k++) begin
        count_val = CNTW'(c); compare_val = CNTW'(k); timer_sel = 3'((c + k) % 8);
        tick("R6 timer compare");
        wipe();
      end

    count_val = 4; compare_val = 4; timer_sel = 2;
    clr_stb = 1; clr_idx = 2; tick("R9 timer beats clear");
    wipe();

    for (int pat = 0; pat < 4; pat++) begin
      logic [7:0] pv;
      pv = (pat == 0) ? 8'h00 : (pat == 1) ? 8'h01 : (pat == 2) ? 8'h80 : 8'h5A;
      wipe();
      for (int b = 0; b < NLEV; b++)
        if (pv[b]) begin post_stb = 1; post_idx = IDXW'(b); tick("R2 preload"); end
      for (int f = 0; f < 8; f++)
        for (int m = 0; m < 256; m++) begin
          glob_en = f[0]; err_lvl = f[1]; exc_lvl = f[2]; irq_mask = 8'(m);
          tick("R8 pending hold");
        end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule